// File: doc/BRIEF.md
# Replicated Kernel Instruction Store

This block keeps the kernel program for a group of compute cores. It holds one private copy of the instruction memory per core, so every core fetches through its own read port in the same cycle and no core ever waits for another. The cores only fetch from it. They have no path to read or write program memory as data.

Loading is done through a single word stream. While the load enable is high, each valid 16-bit word is written into every copy in the same cycle, at consecutive addresses that start at 0 each time loading is entered. Words that arrive after the memory is full are dropped and a sticky overflow flag is raised. The cores are held stopped during loading. A completion pulse then releases them through the run output, and they begin at the first stored word, address 0. Raising the load enable again stops the cores and starts a fresh load.

Top module: `kstore_top`

## Requirements
- R1: After reset `core_run` is 0 and `overflow` is 0.
- R2: When `load_en` is sampled high while not already loading, `core_run` is 0 after that edge, the write address restarts at 0, and `overflow` is cleared. `core_run` stays 0 for as long as `load_en` stays high.
- R3: Each edge that samples `load_en` and `word_valid` both high stores `word_in` into every core's copy, at the address after the last stored word. The first word after entry goes to address 0. An edge with `word_valid` low stores nothing and does not advance the address.
- R4: The memory holds DEPTH words (2048 by default). Once DEPTH words are stored, further words are discarded, and `overflow` goes to 1 after the edge of the first discarded word. It then stays 1 until loading is entered again.
- R5: An edge that samples `load_done` high with `load_en` low, while the block is loading, sets `core_run` to 1 after that edge. The cores then start at address 0.
- R6: `load_done` is ignored while `load_en` is high and while the block is not loading.
- R7: Each core's read port returns the word at the address sampled on the previous edge. All ports work independently and in the same cycle, and every port sees the same contents.
- R8: `word_valid` while `load_en` is low changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| load_en | input | 1 | Programming mode enable (level) |
| word_valid | input | 1 | Qualifies `word_in` |
| word_in | input | INSN_W | Instruction word to store |
| load_done | input | 1 | Programming complete pulse |
| fetch_addr | input | NUM_CORES*ADDR_W | Per-core fetch addresses, core c in slice c |
| fetch_data | output | NUM_CORES*INSN_W | Per-core fetched words, one cycle after the address |
| core_run | output | 1 | 1 releases the cores, 0 holds them in reset |
| overflow | output | 1 | Sticky flag: a word arrived after the memory was full |

## Verification
Programs of random words are loaded with random idle gaps in the valid stream. This tells correct address advance apart from advancing on every cycle. All ports then fetch at independent random addresses, and afterwards all at one shared address, which exposes cross-wired or unbroadcast replicas. A short reload over a longer program shows that entry restarts at 0 and leaves the higher words alone. A load of DEPTH+3 words checks the exact boundary of the overflow flag and that the last accepted word survives. Completion pulses given at the wrong times, and writes given while not loading, must leave the run output and the contents unchanged.

// File: rtl/kstore_pkg.sv
package kstore_pkg;

    typedef enum logic [1:0] {
        MODE_HALT = 2'd0,
        MODE_LOAD = 2'd1,
        MODE_RUN  = 2'd2
    } mode_e;

endpackage

// File: rtl/kstore_ctrl.sv
module kstore_ctrl #(
    parameter int DEPTH  = 2048,
    parameter int INSN_W = 16,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int PTR_W  = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic              word_valid,
    input  logic [INSN_W-1:0] word_in,
    input  logic              load_done,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [INSN_W-1:0] wr_data,
    output logic              core_run,
    output logic              overflow
);
    import kstore_pkg::*;

    typedef struct packed {
        mode_e            mode;
        logic [PTR_W-1:0] ptr;
        logic             ovf;
    } ctrl_s;

    ctrl_s            s_d, s_q;
    logic             entering;
    logic [PTR_W-1:0] base;
    logic             room;
    logic             fire;

    always_comb begin
        s_d      = s_q;
        entering = load_en && (s_q.mode != MODE_LOAD);
        base     = entering ? '0 : s_q.ptr;
        room     = (base < PTR_W'(DEPTH));
        fire     = load_en && word_valid && room;

        // pointer: restarts on entry, advances per accepted word
        s_d.ptr = fire ? (base + PTR_W'(1)) : base;

        // overflow: cleared on entry, set by a word with no room
        if (entering) begin
            s_d.ovf = 1'b0;
        end
        if (load_en && word_valid && !room) begin
            s_d.ovf = 1'b1;
        end

        // mode sequencing
        if (load_en) begin
            s_d.mode = MODE_LOAD;
        end else if ((s_q.mode == MODE_LOAD) && load_done) begin
            s_d.mode = MODE_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{mode: MODE_HALT, ptr: '0, ovf: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_en    = fire;
    assign wr_addr  = base[ADDR_W-1:0];
    assign wr_data  = word_in;
    assign core_run = (s_q.mode == MODE_RUN);
    assign overflow = s_q.ovf;

endmodule

// File: rtl/kstore_bank.sv
module kstore_bank #(
    parameter int DEPTH  = 2048,
    parameter int INSN_W = 16,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [INSN_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [INSN_W-1:0] rd_data
);
    logic [INSN_W-1:0] mem [DEPTH];
    logic [INSN_W-1:0] rd_d, rd_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    always_comb begin
        rd_d = mem[rd_addr];
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign rd_data = rd_q;

endmodule

// File: rtl/kstore_top.sv
module kstore_top #(
    parameter int DEPTH     = 2048,
    parameter int INSN_W    = 16,
    parameter int NUM_CORES = 4,
    localparam int ADDR_W   = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_en,
    input  logic                          word_valid,
    input  logic [INSN_W-1:0]             word_in,
    input  logic                          load_done,
    input  logic [NUM_CORES*ADDR_W-1:0]   fetch_addr,
    output logic [NUM_CORES*INSN_W-1:0]   fetch_data,
    output logic                          core_run,
    output logic                          overflow
);
    logic              bc_en;
    logic [ADDR_W-1:0] bc_addr;
    logic [INSN_W-1:0] bc_data;

    kstore_ctrl #(.DEPTH(DEPTH), .INSN_W(INSN_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (load_en),
        .word_valid (word_valid),
        .word_in    (word_in),
        .load_done  (load_done),
        .wr_en      (bc_en),
        .wr_addr    (bc_addr),
        .wr_data    (bc_data),
        .core_run   (core_run),
        .overflow   (overflow)
    );

    // one private replica per core; the write side is broadcast
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
        kstore_bank #(.DEPTH(DEPTH), .INSN_W(INSN_W)) u_bank (
            .clk     (clk),
            .wr_en   (bc_en),
            .wr_addr (bc_addr),
            .wr_data (bc_data),
            .rd_addr (fetch_addr[c*ADDR_W +: ADDR_W]),
            .rd_data (fetch_data[c*INSN_W +: INSN_W])
        );
    end

endmodule

// File: rtl/kstore_chk.sv
module kstore_chk (
    input logic clk,
    input logic rst_n,
    input logic load_en,
    input logic word_valid,
    input logic load_done,
    input logic core_run,
    input logic overflow
);
    // R2: loading keeps the cores held
    assert_hold_in_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> !core_run);

    // R5 / R6: release only follows an accepted completion pulse
    assert_run_from_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_run) |-> ($past(load_done) && !$past(load_en)));

    // R4: overflow is sticky outside programming entry
    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !load_en) |=> overflow);

    // R4: overflow only rises on a presented word
    assert_ovf_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overflow) |-> $past(load_en && word_valid));

    // R2: overflow only clears on entry to loading
    assert_ovf_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(overflow) |-> $past(load_en));

endmodule

bind kstore_top kstore_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_en    (load_en),
    .word_valid (word_valid),
    .load_done  (load_done),
    .core_run   (core_run),
    .overflow   (overflow)
);

// File: tb/kstore_top_tb.sv
`timescale 1ns/1ps
module kstore_top_tb;
    localparam int DEPTH  = 2048;
    localparam int INSN_W = 16;
    localparam int NC     = 4;
    localparam int AW     = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_en = 1'b0;
    logic word_valid = 1'b0;
    logic [INSN_W-1:0] word_in = '0;
    logic load_done = 1'b0;
    logic [NC*AW-1:0] fetch_addr = '0;
    logic [NC*INSN_W-1:0] fetch_data;
    logic core_run;
    logic overflow;

    int checks = 0;
    int failures = 0;
    int seed_dummy;
    logic [INSN_W-1:0] model [DEPTH];
    int wptr = 0;

    always #2.5 clk = ~clk;

    kstore_top #(.DEPTH(DEPTH), .INSN_W(INSN_W), .NUM_CORES(NC)) u_dut (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .word_valid(word_valid),
        .word_in(word_in), .load_done(load_done), .fetch_addr(fetch_addr),
        .fetch_data(fetch_data), .core_run(core_run), .overflow(overflow)
    );

    function automatic logic [INSN_W-1:0] exp_word(input int a);
        return model[a];
    endfunction

    function automatic logic [INSN_W-1:0] rand_word();
        return INSN_W'($urandom);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // entry cycle without a word
    task automatic enter_load();
        @(negedge clk);
        load_en = 1'b1; word_valid = 1'b0;
        tick();
        wptr = 0;
    endtask

    // one word, optionally preceded by idle gaps with junk data (R3)
    task automatic push_word(input logic [INSN_W-1:0] w, input int gaps);
        for (int g = 0; g < gaps; g++) begin
            @(negedge clk);
            word_valid = 1'b0; word_in = rand_word();
            tick();
        end
        @(negedge clk);
        word_valid = 1'b1; word_in = w;
        tick();
        if (wptr < DEPTH) model[wptr] = w;
        wptr++;
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic finish_load();
        @(negedge clk);
        load_en = 1'b0; word_valid = 1'b0; load_done = 1'b1;
        tick();
        check("R5 core_run after done", 32'(core_run), 32'd1);
        @(negedge clk);
        load_done = 1'b0;
    endtask

    task automatic read_all(input int a0, input int a1, input int a2, input int a3, input string req);
        int ad [NC];
        ad[0] = a0; ad[1] = a1; ad[2] = a2; ad[3] = a3;
        @(negedge clk);
        for (int c = 0; c < NC; c++) fetch_addr[c*AW +: AW] = AW'(ad[c]);
        tick();
        for (int c = 0; c < NC; c++)
            check(req, 32'(fetch_data[c*INSN_W +: INSN_W]), 32'(exp_word(ad[c])));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        seed_dummy = $urandom(32'd20250607);
        repeat (3) @(posedge clk);
        #1;
        check("R1 core_run at reset", 32'(core_run), 32'd0);
        check("R1 overflow at reset", 32'(overflow), 32'd0);
        @(negedge clk) rst_n = 1'b1;
        tick();

        // R6: done while halted is ignored
        @(negedge clk) load_done = 1'b1;
        tick();
        check("R6 done in halt", 32'(core_run), 32'd0);
        @(negedge clk) load_done = 1'b0;

        // R3: random program with random gaps
        enter_load();
        for (int i = 0; i < 100; i++) push_word(rand_word(), int'($urandom_range(0, 2)));

        // R6: done while still loading is ignored
        @(negedge clk) load_done = 1'b1;
        tick();
        check("R6 done while load_en high", 32'(core_run), 32'd0);
        @(negedge clk) load_done = 1'b0;

        finish_load();

        // R7: independent random reads, then shared address
        for (int k = 0; k < 30; k++)
            read_all(int'($urandom_range(0, 99)), int'($urandom_range(0, 99)),
                     int'($urandom_range(0, 99)), int'($urandom_range(0, 99)), "R7 random fetch");
        read_all(0, 0, 0, 0, "R3 R7 address 0 all cores");
        read_all(99, 99, 99, 99, "R3 R7 last word all cores");
        read_all(0, 1, 2, 3, "R3 consecutive order");

        // R8: writes while not loading are dropped
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            word_valid = 1'b1; word_in = ~model[0];
            tick();
        end
        @(negedge clk) word_valid = 1'b0;
        read_all(0, 1, 2, 3, "R8 no write while running");
        check("R8 still running", 32'(core_run), 32'd1);

        // R2: reload holds cores and restarts at 0
        enter_load();
        check("R2 hold on entry", 32'(core_run), 32'd0);
        for (int i = 0; i < 5; i++) push_word(rand_word(), 0);
        finish_load();
        read_all(0, 4, 5, 99, "R2 reload restarts at 0");

        // R4: overflow boundary
        enter_load();
        for (int i = 0; i < DEPTH; i++) push_word(rand_word(), 0);
        check("R4 no overflow at exactly full", 32'(overflow), 32'd0);
        push_word(rand_word(), 0);
        check("R4 overflow after extra word", 32'(overflow), 32'd1);
        push_word(rand_word(), 1);
        push_word(rand_word(), 0);
        check("R4 overflow stays", 32'(overflow), 32'd1);
        finish_load();
        check("R4 overflow sticky in run", 32'(overflow), 32'd1);
        read_all(0, DEPTH - 1, 1024, DEPTH - 2, "R4 contents kept after overflow");

        // R2: entry clears overflow
        enter_load();
        check("R2 overflow cleared on entry", 32'(overflow), 32'd0);
        push_word(rand_word(), 0);
        finish_load();
        read_all(0, 1, DEPTH - 1, 0, "R3 single word reload");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule